// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences the drive levels of a passive multiplexed LCD panel. It runs from a system clock with a one-cycle enable that pulses at 32768 Hz. From that enable it derives a selectable step rate, walks through the active common-line phases, and drives each common line and each segment line with a 2-bit level index. An analog stage outside the block turns each index into a voltage. Seven combinations of multiplex depth (static, 2, 3, 4, 5 or 6 common lines) and bias (static, half, third) are selected by a 3-bit code. Each phase is driven twice, first with positive and then with negative polarity, so that no pixel sees a net DC voltage.

Pixel data lives in a small internal store. Each segment pin has one 6-bit word, and bit p of that word is the pixel that pin drives while common line p is selected. The store is loaded one word per cycle through a write strobe and can be cleared in a single cycle. Two overrides act on the displayed image without touching the stored data: all segments lit, and all segments dark. Two chosen segment pins can blink selected pixels at 1 Hz or 0.5 Hz. The first six segment pins can be turned into extra common-line drivers. A per-pin map bit marks which pins belong to the display at all.

Top module: `lcd_mux_drive`

## Requirements
- R1: While enabled, the sequencer advances one step every 2^(9-k) pulses of `tick32k`, where k is the value of `clkSel` (0 to 3).
- R2: `modeSel` selects the phase count and bias: 000 gives 4 phases at third bias, 001 gives 3 at third, 010 gives 2 at half, 011 gives 3 at half, 100 gives 1 (static), 101 gives 5 at third, 110 gives 6 at third, and 111 behaves as 000.
- R3: Each step drives the current phase first with positive and then with negative polarity. The phases run 0, 1, …, N-1 and then repeat. After reset or enable the sequence starts at phase 0 with positive polarity.
- R4: Levels are coded 0 = ground, 1 = low intermediate, 2 = high intermediate, 3 = full. At third bias, the positive polarity drives the selected common line to 3, unselected common lines to 1, a lit segment to 0 and a dark segment to 2. The negative polarity drives 0, 2, 3 and 1 for the same four cases.
- R5: At half bias, the positive polarity drives the selected common line to 3, unselected lines to 1, a lit segment to 0 and a dark segment to 3. The negative polarity drives 0, 1, 3 and 0. In static mode, the common line and every unused line drive 3 on positive and 0 on negative; a lit segment drives the opposite level and a dark segment the same level.
- R6: A common line at an index at or above the active phase count is driven at the unselected level of the current bias and polarity. It is never driven to a fixed ground or supply level.
- R7: With `lcdEnable` low, every common output and every segment output is 0, and the sequencer is held at phase 0 with positive polarity.
- R8: `allOn` lights every mapped segment and `blankAll` darkens every mapped segment. When both are high, `allOn` wins. Neither one changes the stored pixel data, which shows again once both are released.
- R9: `segWrEn` writes `segWrData` as the pixel word of segment `segWrAddr`, where bit p of the word is the pixel for common line p. A one-cycle `segClr` pulse clears every stored word and takes priority over a write in the same cycle.
- R10: The blink timer counts `tick32k` pulses from reset and runs whether or not the display is enabled. When `blinkFast` is 1, pixels blank while count bit 14 is 1 (1 Hz). When `blinkFast` is 0, they blank while count bit 15 is 1 (0.5 Hz). A blanked pixel p is one on segment pin 22 with `blinkMaskA[p]` set, or on pin 23 with `blinkMaskB[p]` set, and it is shown dark.
- R11: New values on `modeSel` and `clkSel` take effect only after the negative-polarity step of the last phase of a frame, or while the display is disabled.
- R12: A segment pin whose `pinMap` bit is 0 always drives 0. When `allCom` is high, each of segment pins 0 to 5 whose map bit is 1 drives the same level as the common line with the same index.
- R13: During and right after reset, with `lcdEnable` low, all outputs are 0 and the pixel store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick32k | input | 1 | One-cycle enable at 32768 Hz |
| lcdEnable | input | 1 | Display enable |
| clkSel | input | 2 | Step-rate select |
| modeSel | input | 3 | Multiplex and bias select |
| allOn | input | 1 | Force all segments lit |
| blankAll | input | 1 | Force all segments dark |
| segClr | input | 1 | Clear the pixel store |
| allCom | input | 1 | Turn segment pins 0 to 5 into common drivers |
| pinMap | input | NUM_SEG | Per-pin display membership |
| blinkFast | input | 1 | Blink rate: 1 = 1 Hz, 0 = 0.5 Hz |
| blinkMaskA | input | 6 | Blinking pixels on segment pin 22 |
| blinkMaskB | input | 6 | Blinking pixels on segment pin 23 |
| segWrEn | input | 1 | Pixel word write strobe |
| segWrAddr | input | $clog2(NUM_SEG) | Segment index to write |
| segWrData | input | 6 | Pixel word |
| comLvl | output | 12 | Level of common line i at bits [2i+1:2i] |
| segLvl | output | 2*NUM_SEG | Level of segment pin j at bits [2j+1:2j] |

## Verification
The phase counter, polarity flag and divider feed the outputs directly with no extra register. A wrong step count or polarity therefore changes the common-line pattern within one step: 64 to 512 tick pulses, depending on the rate select. A stale mode or rate latch shows up at the first frame boundary as the wrong number of active common lines. A wrong stored word shows on the next visit to that phase. A blink timer fault shows only when the timer crosses into its dark half, which can take up to 32768 tick pulses, so the stimulus runs long enough to cross both rate thresholds.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  localparam int NUM_COM = 6;
  localparam int PH_W    = 3;

  typedef enum logic [1:0] {
    BIAS_STATIC = 2'd0,
    BIAS_HALF   = 2'd1,
    BIAS_THIRD  = 2'd2
  } bias_e;

  typedef enum logic [1:0] {
    DRV_SEL_COM   = 2'd0,
    DRV_UNSEL_COM = 2'd1,
    DRV_SEG_ON    = 2'd2,
    DRV_SEG_OFF   = 2'd3
  } drive_e;

  typedef struct packed {
    logic [PH_W-1:0] numPhases;
    bias_e           bias;
  } modeCfg_t;

  // Strobes and state handed from control to datapath.
  typedef struct packed {
    logic            active;
    logic [PH_W-1:0] phase;
    logic            polNeg;
    bias_e           bias;
    logic [PH_W-1:0] numPhases;
    logic            blinkOff;
  } seq_t;

  function automatic modeCfg_t decodeMode(logic [2:0] code);
    modeCfg_t c;
    unique case (code)
      3'b001:  begin c.numPhases = 3'd3; c.bias = BIAS_THIRD;  end
      3'b010:  begin c.numPhases = 3'd2; c.bias = BIAS_HALF;   end
      3'b011:  begin c.numPhases = 3'd3; c.bias = BIAS_HALF;   end
      3'b100:  begin c.numPhases = 3'd1; c.bias = BIAS_STATIC; end
      3'b101:  begin c.numPhases = 3'd5; c.bias = BIAS_THIRD;  end
      3'b110:  begin c.numPhases = 3'd6; c.bias = BIAS_THIRD;  end
      default: begin c.numPhases = 3'd4; c.bias = BIAS_THIRD;  end
    endcase
    return c;
  endfunction

  // Level index for a line, given bias, polarity and role.
  function automatic logic [1:0] driveLvl(bias_e b, logic neg, drive_e k);
    logic [1:0] p;
    unique case (b)
      BIAS_THIRD: begin
        unique case (k)
          DRV_SEL_COM:   p = 2'd3;
          DRV_UNSEL_COM: p = 2'd1;
          DRV_SEG_ON:    p = 2'd0;
          default:       p = 2'd2;
        endcase
      end
      BIAS_HALF: begin
        unique case (k)
          DRV_SEL_COM:   p = 2'd3;
          DRV_UNSEL_COM: p = 2'd1;
          DRV_SEG_ON:    p = 2'd0;
          default:       p = 2'd3;
        endcase
      end
      default: begin
        p = (k == DRV_SEG_ON) ? 2'd0 : 2'd3;
      end
    endcase
    if (!neg) return p;
    if (b == BIAS_HALF && k == DRV_UNSEL_COM) return 2'd1;
    return 2'd3 - p;
  endfunction

endpackage

// File: rtl/lcd_mux_ctrl.sv
module lcd_mux_ctrl
  import lcd_mux_pkg::*;
#(
  parameter int DIV_EXP    = 9,
  parameter int BLINK_BITS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic       lcdEnable,
  input  logic [1:0] clkSel,
  input  logic [2:0] modeSel,
  input  logic       blinkFast,
  output seq_t       seq
);

  logic [DIV_EXP-1:0]    divCnt;
  logic [DIV_EXP-1:0]    divLimit;
  logic [PH_W-1:0]       phase;
  logic                  polNeg;
  logic [2:0]            actMode;
  logic [1:0]            actClk;
  logic [BLINK_BITS-1:0] blinkCnt;
  modeCfg_t              cfg;
  logic                  stepNow;
  logic                  frameEnd;

  assign cfg      = decodeMode(actMode);
  assign divLimit = DIV_EXP'((33'd1 << (DIV_EXP - int'(actClk))) - 33'd1);
  assign stepNow  = lcdEnable && tick32k && (divCnt == divLimit);
  assign frameEnd = stepNow && polNeg && (phase == cfg.numPhases - 3'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt <= '0;
    end else if (tick32k) begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      phase   <= '0;
      polNeg  <= 1'b0;
      actMode <= '0;
      actClk  <= '0;
    end else if (!lcdEnable) begin
      divCnt  <= '0;
      phase   <= '0;
      polNeg  <= 1'b0;
      actMode <= modeSel;
      actClk  <= clkSel;
    end else if (tick32k) begin
      if (divCnt == divLimit) begin
        divCnt <= '0;
        if (!polNeg) begin
          polNeg <= 1'b1;
        end else begin
          polNeg <= 1'b0;
          if (frameEnd) begin
            phase   <= '0;
            actMode <= modeSel;
            actClk  <= clkSel;
          end else begin
            phase <= phase + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    seq.active    = lcdEnable;
    seq.phase     = phase;
    seq.polNeg    = polNeg;
    seq.bias      = cfg.bias;
    seq.numPhases = cfg.numPhases;
    seq.blinkOff  = blinkFast ? blinkCnt[BLINK_BITS-2] : blinkCnt[BLINK_BITS-1];
  end

  // R3: the phase index never reaches the active phase count
  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rstN)
    phase < cfg.numPhases);

  // R3: a positive step turns into the negative step of the same phase
  a_r3_pol_flip: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && !polNeg) |=> (polNeg && $stable(phase)));

  // R7: a disabled display restarts at phase 0, positive polarity
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    !lcdEnable |=> (phase == '0 && !polNeg));

  // R11: the latched configuration holds between frame boundaries
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (lcdEnable && !frameEnd) |=> ($stable(actMode) && $stable(actClk)));

endmodule

// File: rtl/lcd_mux_datapath.sv
module lcd_mux_datapath
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG     = 24,
  parameter int BLINK_SEG_A = 22,
  parameter int BLINK_SEG_B = 23,
  parameter int SEG_AW      = $clog2(NUM_SEG)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seq_t                   seq,
  input  logic                   allOn,
  input  logic                   blankAll,
  input  logic                   segClr,
  input  logic                   allCom,
  input  logic [NUM_SEG-1:0]     pinMap,
  input  logic [NUM_COM-1:0]     blinkMaskA,
  input  logic [NUM_COM-1:0]     blinkMaskB,
  input  logic                   segWrEn,
  input  logic [SEG_AW-1:0]      segWrAddr,
  input  logic [NUM_COM-1:0]     segWrData,
  output logic [2*NUM_COM-1:0]   comLvl,
  output logic [2*NUM_SEG-1:0]   segLvl
);

  logic [NUM_COM-1:0] memQ [NUM_SEG];
  logic [1:0]         comDrv [NUM_COM];
  logic [1:0]         pinDrv [NUM_SEG];
  logic [NUM_SEG-1:0] rowAny;
  logic [NUM_SEG-1:0] segOffOk;
  logic [NUM_COM-1:0] comFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SEG; s++) memQ[s] <= '0;
    end else if (segClr) begin
      for (int s = 0; s < NUM_SEG; s++) memQ[s] <= '0;
    end else if (segWrEn && (int'(segWrAddr) < NUM_SEG)) begin
      memQ[segWrAddr] <= segWrData;
    end
  end

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    drive_e kind;
    always_comb begin
      kind = ((i < int'(seq.numPhases)) && (i == int'(seq.phase)))
             ? DRV_SEL_COM : DRV_UNSEL_COM;
      comDrv[i] = seq.active ? driveLvl(seq.bias, seq.polNeg, kind) : 2'd0;
    end
    assign comLvl[2*i +: 2] = comDrv[i];
    assign comFull[i]       = (comDrv[i] == 2'd3);
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_pin
    logic [NUM_COM-1:0] pinBlink;
    logic               pixShown;
    logic [1:0]         segDrv;

    if (j == BLINK_SEG_A) begin : g_blink_a
      assign pinBlink = blinkMaskA;
    end else if (j == BLINK_SEG_B) begin : g_blink_b
      assign pinBlink = blinkMaskB;
    end else begin : g_no_blink
      assign pinBlink = '0;
    end

    always_comb begin
      if (allOn)         pixShown = 1'b1;
      else if (blankAll) pixShown = 1'b0;
      else               pixShown = memQ[j][seq.phase] &&
                                    !(pinBlink[seq.phase] && seq.blinkOff);
      segDrv = driveLvl(seq.bias, seq.polNeg, pixShown ? DRV_SEG_ON : DRV_SEG_OFF);
    end

    if (j < NUM_COM) begin : g_shared
      assign pinDrv[j] = (!seq.active || !pinMap[j]) ? 2'd0 :
                         allCom ? comDrv[j] : segDrv;
    end else begin : g_plain
      assign pinDrv[j] = (!seq.active || !pinMap[j]) ? 2'd0 : segDrv;
    end

    assign segLvl[2*j +: 2] = pinDrv[j];
    assign rowAny[j]        = |memQ[j];
    assign segOffOk[j]      = !pinMap[j] || (pinDrv[j] == 2'd2);
  end

  // R9: a clear pulse leaves the whole store empty
  a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rstN)
    segClr |=> (rowAny == '0));

  // R4: exactly one common line at full level in a positive third-bias step
  a_r4_one_selected: assert property (@(posedge clk) disable iff (!rstN)
    (seq.active && seq.bias == BIAS_THIRD && !seq.polNeg) |-> $countones(comFull) == 1);

  // R8: blank alone darkens every mapped segment pin
  a_r8_blank_dark: assert property (@(posedge clk) disable iff (!rstN)
    (seq.active && blankAll && !allOn && !allCom && seq.bias == BIAS_THIRD && !seq.polNeg)
      |-> (&segOffOk));

  // R7: a disabled display drives ground everywhere
  a_r7_ground: assert property (@(posedge clk) disable iff (!rstN)
    !seq.active |-> (comLvl == '0 && segLvl == '0));

endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG     = 24,
  parameter int DIV_EXP     = 9,
  parameter int BLINK_BITS  = 16,
  parameter int BLINK_SEG_A = 22,
  parameter int BLINK_SEG_B = 23,
  localparam int SEG_AW     = $clog2(NUM_SEG)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick32k,
  input  logic                 lcdEnable,
  input  logic [1:0]           clkSel,
  input  logic [2:0]           modeSel,
  input  logic                 allOn,
  input  logic                 blankAll,
  input  logic                 segClr,
  input  logic                 allCom,
  input  logic [NUM_SEG-1:0]   pinMap,
  input  logic                 blinkFast,
  input  logic [5:0]           blinkMaskA,
  input  logic [5:0]           blinkMaskB,
  input  logic                 segWrEn,
  input  logic [SEG_AW-1:0]    segWrAddr,
  input  logic [5:0]           segWrData,
  output logic [11:0]          comLvl,
  output logic [2*NUM_SEG-1:0] segLvl
);

  seq_t seq;

  lcd_mux_ctrl #(
    .DIV_EXP   (DIV_EXP),
    .BLINK_BITS(BLINK_BITS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick32k  (tick32k),
    .lcdEnable(lcdEnable),
    .clkSel   (clkSel),
    .modeSel  (modeSel),
    .blinkFast(blinkFast),
    .seq      (seq)
  );

  lcd_mux_datapath #(
    .NUM_SEG    (NUM_SEG),
    .BLINK_SEG_A(BLINK_SEG_A),
    .BLINK_SEG_B(BLINK_SEG_B),
    .SEG_AW     (SEG_AW)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .seq       (seq),
    .allOn     (allOn),
    .blankAll  (blankAll),
    .segClr    (segClr),
    .allCom    (allCom),
    .pinMap    (pinMap),
    .blinkMaskA(blinkMaskA),
    .blinkMaskB(blinkMaskB),
    .segWrEn   (segWrEn),
    .segWrAddr (segWrAddr),
    .segWrData (segWrData),
    .comLvl    (comLvl),
    .segLvl    (segLvl)
  );

endmodule

// File: tb/lcd_mux_drive_tb.sv
module lcd_mux_drive_tb_top;

  localparam int NSEG = 24;
  localparam int AW   = $clog2(NSEG);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            tick32k = 1'b1;
  logic            lcdEnable = 1'b0;
  logic [1:0]      clkSel = '0;
  logic [2:0]      modeSel = '0;
  logic            allOn = 1'b0;
  logic            blankAll = 1'b0;
  logic            segClr = 1'b0;
  logic            allCom = 1'b0;
  logic [NSEG-1:0] pinMap = '0;
  logic            blinkFast = 1'b0;
  logic [5:0]      blinkMaskA = '0;
  logic [5:0]      blinkMaskB = '0;
  logic            segWrEn = 1'b0;
  logic [AW-1:0]   segWrAddr = '0;
  logic [5:0]      segWrData = '0;
  logic [11:0]     comLvl;
  logic [2*NSEG-1:0] segLvl;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  bit randTick = 1'b0;
  string reqTag = "R13";

  // reference state
  int        mDiv, mPhase, mActMode, mActClk;
  bit        mPol;
  logic [15:0] mBlink;
  logic [5:0]  mMem [NSEG];

  always #2 clk = ~clk;

  lcd_mux_drive dut_i (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .lcdEnable(lcdEnable),
    .clkSel(clkSel), .modeSel(modeSel), .allOn(allOn), .blankAll(blankAll),
    .segClr(segClr), .allCom(allCom), .pinMap(pinMap), .blinkFast(blinkFast),
    .blinkMaskA(blinkMaskA), .blinkMaskB(blinkMaskB), .segWrEn(segWrEn),
    .segWrAddr(segWrAddr), .segWrData(segWrData), .comLvl(comLvl), .segLvl(segLvl)
  );

  function automatic int modeN(int m);
    case (m)
      1: return 3; 2: return 2; 3: return 3; 4: return 1;
      5: return 5; 6: return 6; default: return 4;
    endcase
  endfunction

  // 0 static, 1 half, 2 third
  function automatic int modeBias(int m);
    case (m)
      2, 3: return 1;
      4:    return 0;
      default: return 2;
    endcase
  endfunction

  // k: 0 selected com, 1 unselected com, 2 lit seg, 3 dark seg
  function automatic logic [1:0] refLvl(int b, bit neg, int k);
    if (b == 2) begin
      case (k) 0: return neg ? 2'd0 : 2'd3; 1: return neg ? 2'd2 : 2'd1;
               2: return neg ? 2'd3 : 2'd0; default: return neg ? 2'd1 : 2'd2; endcase
    end else if (b == 1) begin
      case (k) 0: return neg ? 2'd0 : 2'd3; 1: return 2'd1;
               2: return neg ? 2'd3 : 2'd0; default: return neg ? 2'd0 : 2'd3; endcase
    end
    return (k == 2) ? (neg ? 2'd3 : 2'd0) : (neg ? 2'd0 : 2'd3);
  endfunction

  function automatic logic [1:0] expCom(int i);
    if (!lcdEnable) return 2'd0;
    return refLvl(modeBias(mActMode), mPol,
                  (i < modeN(mActMode) && i == mPhase) ? 0 : 1);
  endfunction

  function automatic bit expPix(int j);
    bit px, off;
    if (allOn) return 1'b1;
    if (blankAll) return 1'b0;
    px  = mMem[j][mPhase];
    off = blinkFast ? mBlink[14] : mBlink[15];
    if (j == 22 && blinkMaskA[mPhase] && off) px = 1'b0;
    if (j == 23 && blinkMaskB[mPhase] && off) px = 1'b0;
    return px;
  endfunction

  function automatic logic [1:0] expSeg(int j);
    if (!lcdEnable || !pinMap[j]) return 2'd0;
    if (allCom && j < 6) return expCom(j);
    return refLvl(modeBias(mActMode), mPol, expPix(j) ? 2 : 3);
  endfunction

  task automatic modelUpdate();
    if (!rstN) begin
      mDiv = 0; mPhase = 0; mPol = 1'b0; mActMode = 0; mActClk = 0; mBlink = '0;
      for (int s = 0; s < NSEG; s++) mMem[s] = '0;
      return;
    end
    if (tick32k) mBlink = mBlink + 16'd1;
    if (segClr) begin
      for (int s = 0; s < NSEG; s++) mMem[s] = '0;
    end else if (segWrEn && int'(segWrAddr) < NSEG) begin
      mMem[segWrAddr] = segWrData;
    end
    if (!lcdEnable) begin
      mDiv = 0; mPhase = 0; mPol = 1'b0;
      mActMode = int'(modeSel); mActClk = int'(clkSel);
    end else if (tick32k) begin
      if (mDiv == (1 << (9 - mActClk)) - 1) begin
        mDiv = 0;
        if (!mPol) mPol = 1'b1;
        else begin
          mPol = 1'b0;
          if (mPhase == modeN(mActMode) - 1) begin
            mPhase = 0; mActMode = int'(modeSel); mActClk = int'(clkSel);
          end else mPhase++;
        end
      end else mDiv++;
    end
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s act=%h exp=%h", reqTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [11:0] ec;
    logic [2*NSEG-1:0] es;
    for (int i = 0; i < 6; i++) ec[2*i +: 2] = expCom(i);
    for (int j = 0; j < NSEG; j++) es[2*j +: 2] = expSeg(j);
    chk("comLvl", 64'(comLvl), 64'(ec));
    chk("segLvl", 64'(segLvl), 64'(es));
  endtask

  task automatic runCycles(int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      modelUpdate();
      @(negedge clk);
      compareAll();
      tick32k = randTick ? (($urandom % 4) != 0) : 1'b1;
    end
  endtask

  task automatic wrSeg(int a, logic [5:0] d);
    segWrEn = 1'b1; segWrAddr = AW'(a); segWrData = d;
    runCycles(1);
    segWrEn = 1'b0;
  endtask

  task automatic fillMem();
    for (int s = 0; s < NSEG; s++) wrSeg(s, 6'($urandom));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R13: reset state
    reqTag = "R13 reset";
    runCycles(4);
    rstN = 1'b1;
    runCycles(4);
    // R9: load the store
    reqTag = "R9 write";
    fillMem();
    pinMap = '1; lcdEnable = 1'b1; clkSel = 2'd3;
    // R2 R3 R4 R5 R6 R11: every mode code
    reqTag = "R2 R3 R4 R5 R6 R11 modes";
    for (int m = 0; m < 8; m++) begin
      modeSel = 3'(m);
      runCycles(900);
    end
    // R1: every step rate
    reqTag = "R1 rate";
    modeSel = 3'd2;
    for (int c = 0; c < 4; c++) begin
      clkSel = 2'(c);
      runCycles(2200);
    end
    clkSel = 2'd3; modeSel = 3'd0;
    // R8: overrides
    reqTag = "R8 override";
    allOn = 1'b1;    runCycles(300);
    blankAll = 1'b1; runCycles(300);
    allOn = 1'b0;    runCycles(300);
    blankAll = 1'b0; runCycles(300);
    // R12: shared pins as common lines, partial map
    reqTag = "R12 allcom map";
    allCom = 1'b1; pinMap = NSEG'($urandom); runCycles(700);
    allCom = 1'b0; runCycles(300);
    pinMap = '1;
    // R7: disable
    reqTag = "R7 disable";
    lcdEnable = 1'b0; runCycles(60);
    lcdEnable = 1'b1; runCycles(400);
    // R9: clear beats write
    reqTag = "R9 clear";
    segClr = 1'b1; wrSeg(3, 6'h3f); segClr = 1'b0;
    runCycles(800);
    fillMem();
    // R10: blink at both rates
    reqTag = "R10 blink";
    modeSel = 3'd6; blinkMaskA = 6'b101101; blinkMaskB = 6'b011110;
    wrSeg(22, 6'h3f); wrSeg(23, 6'h3f);
    blinkFast = 1'b1; runCycles(36000);
    blinkFast = 1'b0; runCycles(68000);
    // R1 R2 R3 R11 random mix
    reqTag = "R1 R2 R3 R8 R11 R12 random";
    randTick = 1'b1;
    for (int it = 0; it < 20; it++) begin
      modeSel = 3'($urandom); clkSel = 2'($urandom);
      allOn = (($urandom % 8) == 0); blankAll = (($urandom % 8) == 0);
      allCom = (($urandom % 4) == 0); pinMap = NSEG'($urandom) | NSEG'(24'hc00000);
      blinkFast = 1'($urandom); blinkMaskA = 6'($urandom); blinkMaskB = 6'($urandom);
      lcdEnable = (($urandom % 6) != 0);
      if (($urandom % 3) == 0) wrSeg(int'($urandom % NSEG), 6'($urandom));
      runCycles(800);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule